// File: doc/BRIEF.md
# Parallel Port Register Interface

This block sits between a byte-wide register bus and the pins of a PC-style parallel port. A sequencer or host sees three byte registers: the data byte, a read-only status byte and a control byte. Each register bit maps to a fixed pin, and some of these maps invert the signal. The block also decides whether the eight data lines are driven or released, and it raises an interrupt when the acknowledge input rises while interrupts are enabled.

Every status input goes through a two-flop synchronizer before it is read back or checked for an edge. Reading the data register returns the level on the lines, not the last byte written. So when the drivers are released, a read returns what the attached device is driving.

Top module: `pport_regs`

## Requirements
- R1: Address 0 selects the data register, address 1 the status register and address 2 the control register. Control reads back its bits 5..0 as written, with bits 7..6 reading 0. Address 3 reads 0.
- R2: The status byte is built from the synchronized pins as follows. Bit 7 is the inverse of the busy pin. Bit 6 is the acknowledge pin (active low). Bit 5 is the paper-error pin. Bit 4 is the select pin. Bit 3 is the fault pin (active low). Bits 2..0 read 0.
- R3: A write to address 1 has no effect on the status, control or data registers.
- R4: Control bits drive the pins as follows. Bit 0 appears inverted on the strobe pin. Bit 1 appears inverted on the auto-feed pin. Bit 2 appears unchanged on the init pin. Bit 3 appears inverted on the select-in pin.
- R5: The data output enable is low exactly when the extended-mode input is high and control bit 5 is set. Otherwise it is high.
- R6: A write to address 0 updates the data output lines on the next clock edge. A read at address 0 returns the level on the data input lines, even when the drivers are released.
- R7: If control bit 4 is set, a rising edge of the synchronized acknowledge pin sets the interrupt. A falling edge does not set it, and neither does any edge while bit 4 is clear.
- R8: The interrupt stays high until the control register is written or the acknowledge pulse input is high.
- R9: Reset clears the control and data registers and the interrupt. After reset, all four control pins sit at the levels that control value 0 gives, and the data drivers are enabled.
- R10: A status pin change shows up in the status byte two clock edges after it is sampled, and not one edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write byte |
| bus_rdata | output | DATA_W | Read byte (combinational on address) |
| ext_mode | input | 1 | Extended transfer mode active |
| irq_ack | input | 1 | Clears the interrupt |
| irq | output | 1 | Interrupt request |
| pin_data_out | output | DATA_W | Data line drive value |
| pin_data_oe | output | 1 | Data line drive enable |
| pin_data_in | input | DATA_W | Observed data line level |
| pin_strobe_n | output | 1 | Strobe pin |
| pin_autofd_n | output | 1 | Auto-feed pin |
| pin_init_n | output | 1 | Init pin |
| pin_selin_n | output | 1 | Select-in pin |
| pin_busy | input | 1 | Busy pin |
| pin_ack_n | input | 1 | Acknowledge pin |
| pin_perror | input | 1 | Paper-error pin |
| pin_select | input | 1 | Select pin |
| pin_fault_n | input | 1 | Fault pin |

## Verification
The bench targets several cases.
- Released drivers with a different byte on the lines: a design that returns the latched byte fails the read.
- The status byte one edge after a pin change: a design with a single synchronizer stage shows the new value too early.
- Falling and disabled acknowledge edges: a level-sensitive or always-enabled interrupt would fire on these.
- Each way of clearing the interrupt, tested separately: a missing clear path leaves the interrupt stuck.
- Writes to the status address: a design that decodes the address loosely would corrupt the control or data register.

// File: rtl/pport_pkg.sv
package pport_pkg;
   localparam int STAT_W = 5;
   localparam int CTRL_W = 6;
   // register addresses
   localparam int A_DATA = 0;
   localparam int A_STAT = 1;
   localparam int A_CTRL = 2;
   // control bit positions
   localparam int CB_STROBE = 0;
   localparam int CB_AUTOFD = 1;
   localparam int CB_INIT   = 2;
   localparam int CB_SELIN  = 3;
   localparam int CB_IRQEN  = 4;
   localparam int CB_DIR    = 5;
   // synchronized status vector order
   localparam int SV_FAULT  = 0;
   localparam int SV_SELECT = 1;
   localparam int SV_PERROR = 2;
   localparam int SV_ACK    = 3;
   localparam int SV_BUSY   = 4;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pport_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) st[0] <= '0;
               else        st[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) st[i] <= '0;
               else        st[i] <= st[i-1];
            end
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
   import pport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ext_mode,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] data_q,
   output logic              data_oe,
   output logic              strobe_n,
   output logic              autofd_n,
   output logic              init_n,
   output logic              selin_n
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         data_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
         if (wr_data) data_q <= wdata;
      end
   end

   assign strobe_n = ~ctrl_q[CB_STROBE];
   assign autofd_n = ~ctrl_q[CB_AUTOFD];
   assign init_n   =  ctrl_q[CB_INIT];
   assign selin_n  = ~ctrl_q[CB_SELIN];
   assign data_oe  = ~(ext_mode & ctrl_q[CB_DIR]);
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_s,
   input  logic enable,
   input  logic clr,
   output logic irq
);
   logic ack_prev;
   logic rise;

   assign rise = ack_s & ~ack_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_prev <= 1'b0;
         irq      <= 1'b0;
      end else begin
         ack_prev <= ack_s;
         if (rise && enable) irq <= 1'b1;
         else if (clr)       irq <= 1'b0;
      end
   end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
   import pport_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ext_mode,
   input  logic              irq_ack,
   output logic              irq,
   output logic [DATA_W-1:0] pin_data_out,
   output logic              pin_data_oe,
   input  logic [DATA_W-1:0] pin_data_in,
   output logic              pin_strobe_n,
   output logic              pin_autofd_n,
   output logic              pin_init_n,
   output logic              pin_selin_n,
   input  logic              pin_busy,
   input  logic              pin_ack_n,
   input  logic              pin_perror,
   input  logic              pin_select,
   input  logic              pin_fault_n
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("pport_regs: DATA_W must be 8");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pport_regs: ADDR_W must be at least 2");
      end
   endgenerate

   logic              sel_data, sel_stat, sel_ctrl;
   logic [STAT_W-1:0] stat_raw, stat_s;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] stat_byte;

   assign sel_data = (bus_addr == ADDR_W'(A_DATA));
   assign sel_stat = (bus_addr == ADDR_W'(A_STAT));
   assign sel_ctrl = (bus_addr == ADDR_W'(A_CTRL));

   always_comb begin
      stat_raw            = '0;
      stat_raw[SV_FAULT]  = pin_fault_n;
      stat_raw[SV_SELECT] = pin_select;
      stat_raw[SV_PERROR] = pin_perror;
      stat_raw[SV_ACK]    = pin_ack_n;
      stat_raw[SV_BUSY]   = pin_busy;
   end

   pport_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   (stat_raw),
      .q   (stat_s)
   );

   pport_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_data  (bus_we & sel_data),
      .wr_ctrl  (bus_we & sel_ctrl),
      .wdata    (bus_wdata),
      .ext_mode (ext_mode),
      .ctrl_q   (ctrl_q),
      .data_q   (pin_data_out),
      .data_oe  (pin_data_oe),
      .strobe_n (pin_strobe_n),
      .autofd_n (pin_autofd_n),
      .init_n   (pin_init_n),
      .selin_n  (pin_selin_n)
   );

   pport_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ack_s  (stat_s[SV_ACK]),
      .enable (ctrl_q[CB_IRQEN]),
      .clr    (irq_ack | (bus_we & sel_ctrl)),
      .irq    (irq)
   );

   always_comb begin
      stat_byte    = '0;
      stat_byte[7] = ~stat_s[SV_BUSY];
      stat_byte[6] =  stat_s[SV_ACK];
      stat_byte[5] =  stat_s[SV_PERROR];
      stat_byte[4] =  stat_s[SV_SELECT];
      stat_byte[3] =  stat_s[SV_FAULT];
   end

   always_comb begin
      if (sel_data)      bus_rdata = pin_data_in;
      else if (sel_stat) bus_rdata = stat_byte;
      else if (sel_ctrl) bus_rdata = DATA_W'(ctrl_q);
      else               bus_rdata = '0;
   end
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              ext_mode,
   input logic              irq_ack,
   input logic              irq,
   input logic [DATA_W-1:0] pin_data_out,
   input logic              pin_data_oe,
   input logic              pin_strobe_n,
   input logic              pin_autofd_n,
   input logic              pin_init_n,
   input logic              pin_selin_n
);
   logic ctrl_wr;
   assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(2));

   // R4
   pin_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (pin_strobe_n == ~$past(bus_wdata[0])) && (pin_autofd_n == ~$past(bus_wdata[1]))
                  && (pin_init_n == $past(bus_wdata[2])) && (pin_selin_n == ~$past(bus_wdata[3])));

   // R5
   dir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (pin_data_oe == !(ext_mode && $past(bus_wdata[5]))));

   // R6
   data_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(0)) |=> (pin_data_out == $past(bus_wdata)));

   // R3
   stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(1)) |=> $stable(pin_data_out) && $stable(pin_strobe_n) && $stable(pin_init_n));

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack && !ctrl_wr) |=> irq);

   // R2
   stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(1)) |-> (bus_rdata[2:0] == 3'b000));

   // R1
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(3)) |-> (bus_rdata == '0));
endmodule

bind pport_regs pport_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pport_regs_bench.sv
`timescale 1ns/1ps
module pport_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ext_mode = 1'b0;
   logic       irq_ack = 1'b0;
   logic       irq;
   logic [7:0] pin_data_out, pin_data_in, ext_data = 8'h00;
   logic       pin_data_oe;
   logic       pin_strobe_n, pin_autofd_n, pin_init_n, pin_selin_n;
   logic       pin_busy = 1'b0, pin_ack_n = 1'b0, pin_perror = 1'b0, pin_select = 1'b0, pin_fault_n = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   // line model: driven value wins when enabled, else the far device
   assign pin_data_in = pin_data_oe ? pin_data_out : ext_data;

   pport_regs u_pport_regs (.*);

   // {ext_mode, wdata, expected {oe, strobe_n, autofd_n, init_n, selin_n}}
   localparam logic [13:0] CTRL_VEC [6] = '{
      {1'b0, 8'h00, 5'b11101},
      {1'b0, 8'h3F, 5'b10010},
      {1'b1, 8'h20, 5'b01101},
      {1'b1, 8'h01, 5'b10101},
      {1'b0, 8'h24, 5'b11111},
      {1'b1, 8'h2A, 5'b01000}
   };
   // {busy, ack_n, perror, select, fault_n, expected status byte}
   localparam logic [12:0] STAT_VEC [7] = '{
      {5'b00000, 8'h80},
      {5'b11111, 8'h78},
      {5'b10000, 8'h00},
      {5'b01000, 8'hC0},
      {5'b00100, 8'hA0},
      {5'b00010, 8'h90},
      {5'b00001, 8'h88}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic set_pins(input logic [4:0] p);
      {pin_busy, pin_ack_n, pin_perror, pin_select, pin_fault_n} = p;
   endtask

   initial begin
      #(5.0 * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] r;
      cyc(3);
      // R9 reset state
      check("R9 irq", irq, 0);
      check("R9 oe", pin_data_oe, 1);
      check("R9 pins", {pin_strobe_n, pin_autofd_n, pin_init_n, pin_selin_n}, 4'b1101);
      check("R9 data_out", pin_data_out, 0);
      rst_n = 1'b1;
      cyc(1);
      rd(2'd2, r); check("R9 ctrl readback", r, 0);

      // R4 R5 R1 control table
      foreach (CTRL_VEC[i]) begin
         ext_mode = CTRL_VEC[i][13];
         wr(2'd2, CTRL_VEC[i][12:5]);
         check("R4_R5 pins", {pin_data_oe, pin_strobe_n, pin_autofd_n, pin_init_n, pin_selin_n}, CTRL_VEC[i][4:0]);
         rd(2'd2, r); check("R1 ctrl readback", r, CTRL_VEC[i][12:5] & 8'h3F);
      end
      wr(2'd2, 8'hFF);
      rd(2'd2, r); check("R1 upper ctrl bits", r, 8'h3F);
      wr(2'd2, 8'h00);

      // R2 status table
      foreach (STAT_VEC[i]) begin
         @(negedge clk); set_pins(STAT_VEC[i][12:8]);
         cyc(3);
         rd(2'd1, r); check("R2 status", r, STAT_VEC[i][7:0]);
      end

      // R10 two-edge latency
      @(negedge clk); set_pins(5'b00000);
      cyc(4);
      set_pins(5'b00001);
      cyc(1);
      rd(2'd1, r); check("R10 not yet", r, 8'h80);
      cyc(1);
      rd(2'd1, r); check("R10 visible", r, 8'h88);

      // R6 data drive and line readback
      ext_mode = 1'b0;
      wr(2'd0, 8'hA5);
      check("R6 data_out", pin_data_out, 8'hA5);
      rd(2'd0, r); check("R6 read driven", r, 8'hA5);
      ext_data = 8'h3C; ext_mode = 1'b1;
      wr(2'd2, 8'h20);
      check("R5 released", pin_data_oe, 0);
      rd(2'd0, r); check("R6 read line", r, 8'h3C);
      check("R6 latch kept", pin_data_out, 8'hA5);

      // R3 status write ignored
      wr(2'd1, 8'hFF);
      rd(2'd1, r); check("R3 status", r, 8'h88);
      rd(2'd2, r); check("R3 ctrl", r, 8'h20);
      check("R3 data", pin_data_out, 8'hA5);
      rd(2'd3, r); check("R1 addr3", r, 0);
      ext_mode = 1'b0;

      // R7 rising edge with enable
      set_pins(5'b00000);
      wr(2'd2, 8'h10);
      cyc(4);
      set_pins(5'b01000);
      cyc(2);
      check("R7 not before sync", irq, 0);
      cyc(2);
      check("R7 rise sets", irq, 1);
      // R8 hold then ack
      cyc(5);
      check("R8 hold", irq, 1);
      irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
      check("R8 ack clears", irq, 0);
      // R7 falling edge ignored
      set_pins(5'b00000);
      cyc(5);
      check("R7 fall", irq, 0);
      // R8 control write clears
      set_pins(5'b01000);
      cyc(5);
      check("R7 second rise", irq, 1);
      wr(2'd2, 8'h10);
      check("R8 ctrl write clears", irq, 0);
      // R7 disabled
      set_pins(5'b00000);
      wr(2'd2, 8'h00);
      cyc(4);
      set_pins(5'b01000);
      cyc(6);
      check("R7 disabled", irq, 0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule